// File: doc/BRIEF.md
# Shared-Chain Arithmetic and Logic Unit

This block is the arithmetic and logic unit of a small multicycle datapath. It is purely combinational. It takes two operand words and a 3-bit operation code, and it returns a result word together with a flag that is high when the result is all zeros. The branch-on-equal logic subtracts its two register values and tests that flag.

Addition and subtraction use one ripple chain of full adders. For a subtract, every bit of the second operand goes through an XOR gate controlled by the subtract signal, and the same signal drives the carry into the lowest adder. The chain therefore computes A + ~B + 1, the two's-complement difference, and no separate subtractor is needed. The bitwise operations are AND, OR and XOR. The two shifts move operand A by exactly one position, and each result bit is taken from its neighbour.

The word width is a parameter. The carry out of the top bit is discarded, so arithmetic wraps modulo 2^WIDTH.

Top module: `merged_alu`

## Requirements
- R1: With `op_sel` = 3'b000, `result` equals `opd_a + opd_b` modulo 2^WIDTH.
- R2: With `op_sel` = 3'b001, `result` equals `opd_a - opd_b` modulo 2^WIDTH (two's complement).
- R3: With `op_sel` = 3'b010, `result` equals the bitwise AND of the operands.
- R4: With `op_sel` = 3'b011, `result` equals the bitwise OR of the operands.
- R5: With `op_sel` = 3'b100, `result` equals the bitwise XOR of the operands.
- R6: With `op_sel` = 3'b101, `result` equals `opd_a` shifted left by one. Bit 0 is filled with 0, and `opd_b` has no effect.
- R7: With `op_sel` = 3'b110, `result` equals `opd_a` shifted right by one (logical). The top bit is filled with 0, and `opd_b` has no effect.
- R8: With `op_sel` = 3'b111, `result` is all zeros whatever the operands are.
- R9: `is_zero` is 1 exactly when every bit of `result` is 0, for every code.
- R10: The carry out of the top bit is dropped. For example, all-ones plus one gives zero with `is_zero` high, and zero minus one gives all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First operand; the only source for the shifts |
| opd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code (see R1 to R8) |
| result | output | WIDTH | Operation result |
| is_zero | output | 1 | High when `result` is all zeros |

## Verification
Immediate assertions in the top module are evaluated whenever an input changes. They compare the result of each arithmetic, bitwise and shift code, and of the unused code, against a model of that operation built from the ports. A further assertion in the adder module compares the ripple chain's sum with a behavioural sum for both directions. The zero flag and the wrap at the carry boundary (R9, R10) are shown only by the bench's directed scenarios. The same holds for the fact that the second operand has no effect on the shifts; the bench shows it by changing `opd_b` while `opd_a` stays fixed.

// File: rtl/merged_alu_pkg.sv
// Package: merged_alu_pkg
// Holds the operation codes shared by the unit and its bench.
// Assumes a 3-bit code space; code 3'b111 is left unused on purpose.
package merged_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_SHL  = 3'b101,
        OP_SHR  = 3'b110,
        OP_NONE = 3'b111
    } alu_op_e;

endpackage

// File: rtl/alu_full_adder.sv
// Module: alu_full_adder
// One-bit full adder cell used by the ripple chain.
// Assumes nothing beyond single-bit inputs; purely combinational.
module alu_full_adder (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);

    // sum and majority carry of the three input bits
    always_comb begin
        s_out = x_in ^ y_in ^ c_in;
        c_out = (x_in & y_in) | (x_in & c_in) | (y_in & c_in);
    end

endmodule

// File: rtl/alu_addsub_chain.sv
// Module: alu_addsub_chain
// Adds or subtracts two words on one ripple chain. For a subtract, each bit
// of the second operand is inverted by an XOR with do_sub, and do_sub also
// feeds the lowest carry, which supplies the +1 of two's-complement negation.
// Assumes WIDTH >= 2. The top stage produces no carry out, so results wrap.
module alu_addsub_chain #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_word,
    input  logic [WIDTH-1:0] y_word,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum_word
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] y_cond;
    logic [TOP:0]     carry;

    // conditional inversion of the second operand, one XOR per bit
    always_comb begin
        y_cond = y_word ^ {WIDTH{do_sub}};
    end

    // carry into the least significant stage is the subtract control
    always_comb begin
        carry[0] = do_sub;
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_stage
            if (g < TOP) begin : g_full
                alu_full_adder u_fa (
                    .x_in  (x_word[g]),
                    .y_in  (y_cond[g]),
                    .c_in  (carry[g]),
                    .s_out (sum_word[g]),
                    .c_out (carry[g+1])
                );
            end else begin : g_msb
                // top stage: sum bit only, carry out is not needed
                always_comb begin
                    sum_word[g] = x_word[g] ^ y_cond[g] ^ carry[g];
                end
            end
        end
    endgenerate

    // compare the ripple chain with a behavioural sum or difference
    always_comb begin : chk_chain
        if (do_sub) begin
            AST_CHAIN_DIFF: assert (sum_word == x_word - y_word)
                else $error("chain difference mismatch"); // R2
        end else begin
            AST_CHAIN_SUM: assert (sum_word == x_word + y_word)
                else $error("chain sum mismatch"); // R1
        end
    end

endmodule

// File: rtl/alu_shift_one.sv
// Module: alu_shift_one
// Moves a word by exactly one bit position. Each output bit is taken from
// its neighbour, and the vacated end is filled with 0.
// Assumes WIDTH >= 2. TO_LEFT selects the direction at elaboration.
module alu_shift_one #(
    parameter int WIDTH   = 32,
    parameter bit TO_LEFT = 1'b1
) (
    input  logic [WIDTH-1:0] src_word,
    output logic [WIDTH-1:0] dst_word
);

    localparam int TOP = WIDTH - 1;

    genvar g;
    generate
        if (TO_LEFT) begin : g_left
            // bit i takes bit i-1; bit 0 is filled with zero
            always_comb begin
                dst_word[0] = 1'b0;
            end
            for (g = 1; g < WIDTH; g++) begin : g_bit
                always_comb begin
                    dst_word[g] = src_word[g-1];
                end
            end
        end else begin : g_right
            // bit i takes bit i+1; the top bit is filled with zero
            always_comb begin
                dst_word[TOP] = 1'b0;
            end
            for (g = 0; g < TOP; g++) begin : g_bit
                always_comb begin
                    dst_word[g] = src_word[g+1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/merged_alu.sv
// Module: merged_alu
// Combinational ALU with seven operations selected by a 3-bit code. Add and
// subtract share alu_addsub_chain; the shifts move operand A by one bit.
// Code 3'b111 gives zero. is_zero reports an all-zero result.
// Assumes WIDTH >= 2. Carry out and overflow are not produced.
module merged_alu
    import merged_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             is_zero
);

    logic             sub_en;
    logic [WIDTH-1:0] arith_out;
    logic [WIDTH-1:0] shl_out;
    logic [WIDTH-1:0] shr_out;

    // subtract control for the shared chain
    always_comb begin
        sub_en = (op_sel == OP_SUB);
    end

    alu_addsub_chain #(.WIDTH(WIDTH)) u_chain (
        .x_word   (opd_a),
        .y_word   (opd_b),
        .do_sub   (sub_en),
        .sum_word (arith_out)
    );

    alu_shift_one #(.WIDTH(WIDTH), .TO_LEFT(1'b1)) u_shl (
        .src_word (opd_a),
        .dst_word (shl_out)
    );

    alu_shift_one #(.WIDTH(WIDTH), .TO_LEFT(1'b0)) u_shr (
        .src_word (opd_a),
        .dst_word (shr_out)
    );

    // select the result for the requested operation
    always_comb begin
        case (alu_op_e'(op_sel))
            OP_ADD, OP_SUB: result = arith_out;
            OP_AND:         result = opd_a & opd_b;
            OP_OR:          result = opd_a | opd_b;
            OP_XOR:         result = opd_a ^ opd_b;
            OP_SHL:         result = shl_out;
            OP_SHR:         result = shr_out;
            default:        result = '0;
        endcase
    end

    // zero flag for the branch-on-equal decision
    always_comb begin
        is_zero = ~|result;
    end

    // per-code checks of the output against port-level models
    always_comb begin : chk_ops
        if (op_sel == OP_ADD) begin
            AST_ADD_WORD: assert (result == opd_a + opd_b)
                else $error("add result"); // R1
        end
        if (op_sel == OP_SUB) begin
            AST_SUB_WORD: assert (result == opd_a + ~opd_b + 1'b1)
                else $error("sub result"); // R2
        end
        if (op_sel == OP_AND) begin
            AST_AND_WORD: assert ((result & ~opd_a) == '0 && (result & ~opd_b) == '0
                                  && (result | ~(opd_a & opd_b)) == '1)
                else $error("and result"); // R3
        end
        if (op_sel == OP_OR) begin
            AST_OR_WORD: assert (~result == (~opd_a & ~opd_b))
                else $error("or result"); // R4
        end
        if (op_sel == OP_XOR) begin
            AST_XOR_WORD: assert ((result ^ opd_b) == opd_a)
                else $error("xor result"); // R5
        end
        if (op_sel == OP_SHL) begin
            AST_SHL_WORD: assert (result == (opd_a << 1))
                else $error("shift left result"); // R6
        end
        if (op_sel == OP_SHR) begin
            AST_SHR_WORD: assert (result == (opd_a >> 1))
                else $error("shift right result"); // R7
        end
        if (op_sel == OP_NONE) begin
            AST_NONE_ZERO: assert ($countones(result) == 0)
                else $error("unused code result"); // R8
        end
    end

endmodule

// File: tb/test_merged_alu.sv
// Bench: test_merged_alu
// Directed scenarios, one task per scenario, each checking its own results.
module test_merged_alu;
    import merged_alu_pkg::*;

    localparam int W = 32;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opd_a = '0;
    logic [W-1:0] opd_b = '0;
    logic [2:0]   op_sel = OP_ADD;
    logic [W-1:0] result;
    logic         is_zero;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    merged_alu #(.WIDTH(W)) i_merged_alu (
        .opd_a   (opd_a),
        .opd_b   (opd_b),
        .op_sel  (op_sel),
        .result  (result),
        .is_zero (is_zero)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    // apply one operation and sample mid-cycle
    task automatic apply(input logic [2:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        op_sel = s;
        opd_a  = a;
        opd_b  = b;
        @(negedge clk);
    endtask

    task automatic chk_word(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s result got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_flag(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s is_zero got %b expected %b", req, got, exp);
        end
    endtask

    // reset state: zero operands, add code gives zero and a high flag
    task automatic t_reset_state();
        @(negedge clk);
        chk_word("R1", result, '0);
        chk_flag("R9", is_zero, 1'b1);
    endtask

    // R1 and R2 on several operand pairs
    task automatic t_arith();
        logic [W-1:0] av [4] = '{32'h1234_5678, 32'h0000_0001, 32'h8000_0000, 32'hDEAD_BEEF};
        logic [W-1:0] bv [4] = '{32'h0F0F_0F0F, 32'h0000_0001, 32'h7FFF_FFFF, 32'h1111_2222};
        for (int i = 0; i < 4; i++) begin
            apply(OP_ADD, av[i], bv[i]);
            chk_word("R1", result, av[i] + bv[i]);
            apply(OP_SUB, av[i], bv[i]);
            chk_word("R2", result, av[i] - bv[i]);
            chk_flag("R9", is_zero, (av[i] == bv[i]));
        end
    endtask

    // R3, R4, R5 on contrasting bit patterns
    task automatic t_logic();
        logic [W-1:0] av [3] = '{32'hAAAA_5555, 32'hFFFF_0000, 32'h0F0F_F0F0};
        logic [W-1:0] bv [3] = '{32'h5555_AAAA, 32'h00FF_FF00, 32'h0F0F_F0F0};
        for (int i = 0; i < 3; i++) begin
            apply(OP_AND, av[i], bv[i]);
            chk_word("R3", result, av[i] & bv[i]);
            chk_flag("R9", is_zero, ((av[i] & bv[i]) == '0));
            apply(OP_OR, av[i], bv[i]);
            chk_word("R4", result, av[i] | bv[i]);
            apply(OP_XOR, av[i], bv[i]);
            chk_word("R5", result, av[i] ^ bv[i]);
            chk_flag("R9", is_zero, ((av[i] ^ bv[i]) == '0));
        end
    endtask

    // R6 and R7: fill bits, end bits, and opd_b having no effect
    task automatic t_shift();
        apply(OP_SHL, 32'h8000_0001, 32'h0);
        chk_word("R6", result, 32'h0000_0002);
        apply(OP_SHL, 32'h8000_0001, ONES);
        chk_word("R6", result, 32'h0000_0002);
        apply(OP_SHL, 32'h8000_0000, ONES);
        chk_word("R6", result, '0);
        chk_flag("R9", is_zero, 1'b1);
        apply(OP_SHR, 32'h8000_0001, 32'h0);
        chk_word("R7", result, 32'h4000_0000);
        apply(OP_SHR, 32'h8000_0001, ONES);
        chk_word("R7", result, 32'h4000_0000);
        apply(OP_SHR, ONES, 32'h1234_5678);
        chk_word("R7", result, 32'h7FFF_FFFF);
    endtask

    // R8: unused code forces zero for any operands
    task automatic t_unused_code();
        apply(OP_NONE, ONES, ONES);
        chk_word("R8", result, '0);
        chk_flag("R9", is_zero, 1'b1);
        apply(OP_NONE, 32'h1234_5678, 32'h0000_0001);
        chk_word("R8", result, '0);
    endtask

    // R10: carry out dropped at both ends of the range
    task automatic t_wrap();
        apply(OP_ADD, ONES, 32'h1);
        chk_word("R10", result, '0);
        chk_flag("R10", is_zero, 1'b1);
        apply(OP_SUB, 32'h0, 32'h1);
        chk_word("R10", result, ONES);
        chk_flag("R10", is_zero, 1'b0);
        apply(OP_SUB, 32'h5A5A_5A5A, 32'h5A5A_5A5A);
        chk_word("R10", result, '0);
        chk_flag("R9", is_zero, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_arith();
        t_logic();
        t_shift();
        t_unused_code();
        t_wrap();
        done = 1'b1;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired got running expected done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule